// File: doc/BRIEF.md
# Display Memory Host Port with Bus Holder

This block connects a host bus to a small on-chip display memory through a single staging register, the bus holder. Writes are parked in the holder and committed to memory in the following cycle. Reads hand the host whatever the holder already contains and reload the holder from the addressed location at the same time. Read data therefore always lags by one access. After any address load or any write, the host must perform one throw-away read before it gets valid data.

The host drives three one-cycle strobes: address load, write and read. No wait or busy signal exists; the host only has to respect a minimum spacing between strobes. A strobe that lands in the busy cycle after a write or read is parked in a one-entry slot and carried out as soon as the port is free. The memory port signals are brought out so that every access can be observed.

Top module: `dispHolderBus`

## Requirements
- R1: After reset the holder, the address and the read data output are all zero, and no memory access is signalled (memEn = 0, memWe = 0).
- R2: A write strobe loads dataIn into the holder at the accepting clock edge. In the next cycle memWe = 1 with memAddr equal to the current address and memWdata equal to that data. The address then advances by one.
- R3: A read strobe places the holder's previous contents on rdData at the accepting edge. The holder is then refilled from memory at the current address, and the address advances by one. rdData keeps its value until the next accepted read.
- R4: The first read after an address load returns stale holder contents. The second read returns the byte stored at the loaded address.
- R5: The first read after a write returns the value just written. The next read returns the byte at the address following the written one.
- R6: An address load takes effect at its accepting edge without any memory access (memEn stays 0), and the next access uses the loaded address.
- R7: A strobe that arrives in the busy cycle right after a write or read is not lost. It is carried out once that access completes, in arrival order, with the same result as if it had been spaced out.
- R8: When several strobes are high in one cycle, address load beats write and write beats read; the losing strobes are discarded with no effect on memory, holder or rdData.
- R9: The address wraps from the last location (2^AW - 1) to 0.
- R10: The memory sees at most one access per cycle, and a commit never occurs in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addrSetEn | input | 1 | Address load strobe |
| addrIn | input | AW | Address to load |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| dataIn | input | DW | Write data |
| rdData | output | DW | Data returned by the last read |
| memEn | output | 1 | Memory port access this cycle |
| memWe | output | 1 | Memory port access is a write |
| memAddr | output | AW | Current memory address |
| memWdata | output | DW | Data presented for a memory write |

## Verification
The hardest case to reach from the ports is the deferred strobe. It is a second request that lands in the single busy cycle after a write or read, and then has to be replayed from the slot while the port is idle. The bench reaches it by raising a write or read strobe on the cycle immediately after a write is accepted. It then checks the replayed commit on the memory port and the value later returned through the one-late read path. A full write sweep over all 256 locations, followed by 257 consecutive reads, exercises the lag, the dummy read and the address wrap together.

// File: rtl/dispHolderPkg.sv
package dispHolderPkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_SET  = 2'd1,
    REQ_WR   = 2'd2,
    REQ_RD   = 2'd3
  } reqKindT;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_FILL   = 2'd2
  } portStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic setAddr;
    logic loadHost;
    logic outHolder;
    logic memRead;
    logic commit;
    logic fillHolder;
    logic incAddr;
  } dpStrobeT;

endpackage

// File: rtl/dispHolderCtrl.sv
module dispHolderCtrl
  import dispHolderPkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrSetEn,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [PW-1:0] hostPayload,
  output dpStrobeT      strobe,
  output logic [PW-1:0] curPayload,
  output logic          acceptFree
);

  portStateT stateQ, stateD;
  reqKindT   hostKind, curKind;
  reqKindT   slotKindQ;
  logic [PW-1:0] slotPayloadQ;
  logic      slotValidQ;
  logic      hostValid;

  // priority: address load, then write, then read
  always_comb begin
    if (addrSetEn)  hostKind = REQ_SET;
    else if (wrEn)  hostKind = REQ_WR;
    else if (rdEn)  hostKind = REQ_RD;
    else            hostKind = REQ_NONE;
  end

  assign hostValid  = (hostKind != REQ_NONE);
  assign curKind    = slotValidQ ? slotKindQ : hostKind;
  assign curPayload = slotValidQ ? slotPayloadQ : hostPayload;
  assign acceptFree = (stateQ == ST_IDLE) && !slotValidQ;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        unique case (curKind)
          REQ_SET: strobe.setAddr = 1'b1;
          REQ_WR: begin
            strobe.loadHost = 1'b1;
            stateD          = ST_COMMIT;
          end
          REQ_RD: begin
            strobe.outHolder = 1'b1;
            strobe.memRead   = 1'b1;
            stateD           = ST_FILL;
          end
          default: ;
        endcase
      end
      ST_COMMIT: begin
        strobe.commit  = 1'b1;
        strobe.incAddr = 1'b1;
        stateD         = ST_IDLE;
      end
      ST_FILL: begin
        strobe.fillHolder = 1'b1;
        strobe.incAddr    = 1'b1;
        stateD            = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  // one-entry deferral slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValidQ   <= 1'b0;
      slotKindQ    <= REQ_NONE;
      slotPayloadQ <= '0;
    end else if (stateQ != ST_IDLE) begin
      if (hostValid) begin
        slotValidQ   <= 1'b1;
        slotKindQ    <= hostKind;
        slotPayloadQ <= hostPayload;
      end
    end else if (slotValidQ) begin
      slotValidQ   <= hostValid;
      slotKindQ    <= hostKind;
      slotPayloadQ <= hostPayload;
    end
  end

endmodule

// File: rtl/dispHolderDp.sv
module dispHolderDp
  import dispHolderPkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobeT      strobe,
  input  logic [PW-1:0] payload,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] holderQ,
  output logic [DW-1:0] memQ,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata
);

  localparam int MEM_DEPTH = 1 << AW;

  logic [AW-1:0] addrQ;
  logic [DW-1:0] memArr [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.setAddr) begin
      addrQ <= payload[AW-1:0];
    end else if (strobe.incAddr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holderQ <= '0;
    end else if (strobe.loadHost) begin
      holderQ <= payload[DW-1:0];
    end else if (strobe.fillHolder) begin
      holderQ <= memQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.outHolder) begin
      rdData <= holderQ;
    end
  end

  // single-port synchronous array
  always_ff @(posedge clk) begin
    if (strobe.commit) begin
      memArr[addrQ] <= holderQ;
    end
    if (strobe.memRead) begin
      memQ <= memArr[addrQ];
    end
  end

  assign memEn    = strobe.commit | strobe.memRead;
  assign memWe    = strobe.commit;
  assign memAddr  = addrQ;
  assign memWdata = holderQ;

endmodule

// File: rtl/dispHolderBus.sv
module dispHolderBus
  import dispHolderPkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          addrSetEn,
  input  logic [AW-1:0] addrIn,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] rdData,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata
);

  localparam int PW = (AW > DW) ? AW : DW;

  dpStrobeT      strobe;
  logic [PW-1:0] hostPayload;
  logic [PW-1:0] curPayload;
  logic          acceptFree;
  logic [DW-1:0] holderQ;
  logic [DW-1:0] memQ;

  assign hostPayload = addrSetEn ? PW'(addrIn) : PW'(dataIn);

  dispHolderCtrl #(.PW(PW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrSetEn  (addrSetEn),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .hostPayload(hostPayload),
    .strobe     (strobe),
    .curPayload (curPayload),
    .acceptFree (acceptFree)
  );

  dispHolderDp #(.AW(AW), .DW(DW), .PW(PW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .payload (curPayload),
    .rdData  (rdData),
    .holderQ (holderQ),
    .memQ    (memQ),
    .memEn   (memEn),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memWdata(memWdata)
  );

endmodule

// File: rtl/dispHolderBusChk.sv
module dispHolderBusChk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          addrSetEn,
  input logic          wrEn,
  input logic          rdEn,
  input logic [DW-1:0] dataIn,
  input logic [DW-1:0] rdData,
  input logic          memEn,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          acceptFree,
  input logic [DW-1:0] holderQ,
  input logic [DW-1:0] memQ
);

  AST_WRITE_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSetEn && acceptFree) |=> (memWe && memWdata == $past(dataIn))); // R2

  AST_READ_OLD_HOLDER: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !addrSetEn && acceptFree) |=> (rdData == $past(holderQ))); // R3

  AST_HOLDER_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> ##1 (holderQ == $past(memQ))); // R3

  AST_SET_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (addrSetEn && acceptFree) |-> !memEn); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (memAddr == AW'($past(memAddr) + 1'b1))); // R9

  AST_COMMIT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R10

  AST_WE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn); // R10

endmodule

bind dispHolderBus dispHolderBusChk #(.AW(AW), .DW(DW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .addrSetEn (addrSetEn),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .dataIn    (dataIn),
  .rdData    (rdData),
  .memEn     (memEn),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .acceptFree(acceptFree),
  .holderQ   (holderQ),
  .memQ      (memQ)
);

// File: tb/sim_dispHolderBus.sv
module sim_dispHolderBus;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrSetEn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] rdData;
  logic          memEn;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model of the requirements
  logic [DW-1:0] mdlMem [DEPTH];
  logic [DW-1:0] mdlHolder = '0;
  logic [AW-1:0] mdlAddr = '0;

  always #5 clk = ~clk;

  dispHolderBus #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .addrSetEn(addrSetEn), .addrIn(addrIn),
    .wrEn(wrEn), .rdEn(rdEn), .dataIn(dataIn), .rdData(rdData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(int i);
    return DW'((i * 37 + 11) & ((1 << DW) - 1));
  endfunction

  task automatic doSet(logic [AW-1:0] a);
    @(negedge clk);
    addrSetEn = 1'b1; addrIn = a;
    #1 check("R6 no access on address load", memEn, 0);
    @(negedge clk);
    addrSetEn = 1'b0;
    check("R6 loaded address", memAddr, a);
    mdlAddr = a;
  endtask

  task automatic doWr(logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; dataIn = d;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2 commit strobe", memWe, 1);
    check("R2 commit address", memAddr, mdlAddr);
    check("R2 commit data", memWdata, d);
    mdlMem[mdlAddr] = d;
    mdlHolder = d;
    mdlAddr = mdlAddr + 1'b1;
    @(negedge clk);
  endtask

  task automatic doRd(string req);
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(req, rdData, mdlHolder);
    mdlHolder = mdlMem[mdlAddr];
    mdlAddr = mdlAddr + 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] prevRd;
    for (int i = 0; i < DEPTH; i++) mdlMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData after reset", rdData, 0);
    check("R1 address after reset", memAddr, 0);
    check("R1 no access after reset", memEn, 0);
    check("R1 no write after reset", memWe, 0);
    doRd("R1 holder zero after reset");

    // full write sweep, address wraps (R9)
    doSet('0);
    for (int i = 0; i < DEPTH; i++) doWr(pattern(i));
    check("R9 address wrapped to zero", memAddr, 0);

    // full read sweep: first read is the last written value (R5), then R3 lag
    doSet('0);
    doRd("R5 first read after write returns written value");
    for (int i = 0; i < DEPTH; i++) doRd("R3 one-late read data");
    check("R9 address wrapped after reads", memAddr, 1);

    // dummy read after address load (R4)
    doSet(8'd100);
    doRd("R4 first read after load is stale");
    check("R4 stale value is prior holder", rdData, pattern(0));
    doRd("R4 second read returns loaded location");
    check("R4 data of location 100", rdData, pattern(100));

    // read after write (R5)
    doWr(8'hC3);
    doRd("R5 read after write returns written byte");
    doRd("R5 next read returns following location");
    check("R5 following location value", rdData, pattern(103));

    // R7: write deferred behind a write
    doSet(8'd20);
    @(negedge clk); wrEn = 1'b1; dataIn = 8'hA1;
    @(negedge clk); dataIn = 8'hB2;
    check("R7 first commit data", memWdata, 8'hA1);
    check("R7 first commit address", memAddr, 20);
    @(negedge clk); wrEn = 1'b0;
    check("R7 no commit while replaying", memWe, 0);
    @(negedge clk);
    check("R7 deferred commit strobe", memWe, 1);
    check("R7 deferred commit data", memWdata, 8'hB2);
    check("R7 deferred commit address", memAddr, 21);
    @(negedge clk);
    mdlMem[20] = 8'hA1; mdlMem[21] = 8'hB2; mdlHolder = 8'hB2; mdlAddr = 8'd22;

    // R7: read deferred behind a write
    @(negedge clk); wrEn = 1'b1; dataIn = 8'h5C;
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    @(negedge clk);
    check("R7 deferred read returns written byte", rdData, 8'h5C);
    @(negedge clk);
    mdlMem[22] = 8'h5C; mdlHolder = mdlMem[23]; mdlAddr = 8'd24;
    doSet(8'd20);
    doRd("R7 dummy read");
    doRd("R7 first burst byte stored");
    doRd("R7 second burst byte stored");
    doRd("R7 deferred-read write stored");

    // R8: write beats read
    prevRd = rdData;
    @(negedge clk); wrEn = 1'b1; rdEn = 1'b1; dataIn = 8'h6E;
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    check("R8 write wins over read", memWe, 1);
    check("R8 losing read leaves rdData", rdData, prevRd);
    @(negedge clk);
    mdlMem[mdlAddr] = 8'h6E; mdlHolder = 8'h6E; mdlAddr = mdlAddr + 1'b1;

    // R8: address load beats write
    @(negedge clk); addrSetEn = 1'b1; addrIn = 8'd7; wrEn = 1'b1; dataIn = 8'hFF;
    @(negedge clk); addrSetEn = 1'b0; wrEn = 1'b0;
    check("R8 load wins, no commit", memWe, 0);
    check("R8 load wins, address", memAddr, 7);
    @(negedge clk);
    check("R8 dropped write never commits", memWe, 0);
    mdlAddr = 8'd7;
    doRd("R8 holder untouched by dropped write");
    doRd("R8 location 7 untouched");
    check("R8 location 7 value", rdData, pattern(7));

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule